// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt lines into one request line for a processor. Each line has a pending bit, which follows the line's level, and an enable bit, which software controls. The request output is high whenever at least one line is both pending and enabled.

Software reaches the block through a small word-wide register window. It turns enables on with a bit-set write and off with a bit-clear write. A single global write drops every enable and every pending bit. Two read registers report the enabled pending lines: one gives them as a bit mask, the other gives how many there are.

An optional synchronizer chain in front of the pending bits is selected by a parameter. With the default of zero stages, the lines are taken as synchronous.

Top module: `irq_gather`

## Requirements
- R1: After reset the enable and pending masks are zero, `irq_out` is low, and both read registers return 0.
- R2: On each clock edge, a line that is high sets its pending bit and a line that is low clears it (with zero synchronizer stages, this happens on the first edge after the line changes).
- R3: A write to offset 0x10 sets every enable bit whose data bit is 1 and leaves the other enable bits as they were.
- R4: A write to offset 0x0C clears every enable bit whose data bit is 1 and leaves the other enable bits as they were.
- R5: A write to offset 0x08, whatever its data, clears the whole enable mask and the whole pending mask. `irq_out` is low in the cycle after that write.
- R6: A line that is still high after the global clear sets its pending bit again on the next edge, so enabling it again raises `irq_out`.
- R7: A read of offset 0x00 returns the number of bits set in (pending AND enable), a value from 0 to 32, in the low bits.
- R8: A read of offset 0x04 returns (pending AND enable), never the raw pending bits.
- R9: `irq_out` is high exactly when (pending AND enable) is nonzero. It follows every line change and every register write one clock later.
- R10: Reads of any other byte address, including unaligned ones and the write-only offsets, return 0. Writes to any address other than 0x08, 0x0C and 0x10 change nothing.
- R11: Read data appears on `bus_rdata` on the clock after the read strobe. It is 0 in any cycle that follows a clock with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, the embedded properties check the following:
- `irq_out` agrees with the population count of the enabled pending lines.
- After a global clear, `irq_out` is low.
- A set write or a clear write leaves exactly the written enable bits on or off.
- Writes to other addresses leave the enable mask unchanged.
- A mask read never shows a bit that was not enabled, and a status read never exceeds the line count.

Only the bench scenarios can show the following:
- The exact counts and masks for chosen line patterns.
- The re-pending of a line that stays high after the global clear.
- The zero read-back of unmapped and unaligned addresses.
- The one-cycle read latency.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

   // Byte offsets of the register window.
   typedef enum logic [7:0] {
      OFS_COUNT = 8'h00,
      OFS_MASK  = 8'h04,
      OFS_KILL  = 8'h08,
      OFS_OFF   = 8'h0C,
      OFS_ON    = 8'h10
   } reg_ofs_e;

   // Decoded write action.
   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_SET,
      ACT_CLR,
      ACT_KILL
   } wr_act_e;

endpackage

// File: rtl/irq_gather_capture.sv
module irq_gather_capture #(
   parameter int NUM_SRC     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               clr_all_i,
   output logic [NUM_SRC-1:0] pend_o
);

   logic [NUM_SRC-1:0] src_s;
   logic [NUM_SRC-1:0] pend_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign src_s = src_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][NUM_SRC-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= src_i;
               for (int s = 1; s < SYNC_STAGES; s++) begin
                  sync_q[s] <= sync_q[s-1];
               end
            end
         end
         assign src_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   // The pending bit follows the line level; the global clear wins for one edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (clr_all_i) begin
         pend_q <= '0;
      end else begin
         pend_q <= src_s;
      end
   end

   assign pend_o = pend_q;

   // R5
   kill_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> (pend_o == '0));

endmodule

// File: rtl/irq_gather_enable.sv
module irq_gather_enable #(
   parameter int NUM_SRC = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  irq_gather_pkg::wr_act_e      act_i,
   input  logic [NUM_SRC-1:0]           data_i,
   output logic [NUM_SRC-1:0]           en_o
);
   import irq_gather_pkg::*;

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] en_d;

   always_comb begin
      unique case (act_i)
         ACT_SET:  en_d = en_q | data_i;
         ACT_CLR:  en_d = en_q & ~data_i;
         ACT_KILL: en_d = '0;
         default:  en_d = en_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   assign en_o = en_q;

   // R3
   set_bits_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_SET) |=> ((en_o & $past(data_i)) == $past(data_i)));

   // R4
   clr_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_CLR) |=> ((en_o & $past(data_i)) == '0));

   // R3 R4: bits outside the written ones keep their value
   untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_i == ACT_SET) || (act_i == ACT_CLR)) |=>
      ((en_o & ~$past(data_i)) == ($past(en_o) & ~$past(data_i))));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_NONE) |=> $stable(en_o));

endmodule

// File: rtl/irq_gather_count.sv
module irq_gather_count #(
   parameter int NUM_SRC = 32,
   parameter int CNT_W   = 6
) (
   input  logic [NUM_SRC-1:0] vec_i,
   output logic [CNT_W-1:0]   cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         cnt_o = cnt_o + CNT_W'(vec_i[i]);
      end
   end

endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out
);
   import irq_gather_pkg::*;

   localparam int CNT_W = $clog2(NUM_SRC + 1);

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie between 1 and DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must be at least 5");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   wr_act_e            act;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] live;
   logic [CNT_W-1:0]   cnt;
   logic [DATA_W-1:0]  rd_val;
   logic [DATA_W-1:0]  rdata_q;

   always_comb begin
      act = ACT_NONE;
      if (bus_wr) begin
         if      (bus_addr == ADDR_W'(OFS_ON))   act = ACT_SET;
         else if (bus_addr == ADDR_W'(OFS_OFF))  act = ACT_CLR;
         else if (bus_addr == ADDR_W'(OFS_KILL)) act = ACT_KILL;
      end
   end

   irq_gather_capture #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i),
      .clr_all_i (act == ACT_KILL),
      .pend_o    (pend)
   );

   irq_gather_enable #(.NUM_SRC(NUM_SRC)) u_enable (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .data_i (bus_wdata[NUM_SRC-1:0]),
      .en_o   (en)
   );

   assign live = pend & en;

   irq_gather_count #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_count (
      .vec_i (live),
      .cnt_o (cnt)
   );

   always_comb begin
      rd_val = '0;
      if      (bus_addr == ADDR_W'(OFS_COUNT)) rd_val = DATA_W'(cnt);
      else if (bus_addr == ADDR_W'(OFS_MASK))  rd_val = DATA_W'(live);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_val;
      else             rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;
   assign irq_out   = |live;

   // R9
   irq_vs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (cnt != '0));

   // R5
   kill_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_KILL)) |=> !irq_out);

   // R7
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_COUNT)) |=> (bus_rdata <= DATA_W'(NUM_SRC)));

   // R8
   mask_in_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_MASK)) |=>
      ((bus_rdata[NUM_SRC-1:0] & ~$past(en)) == '0));

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/sim_irq_gather.sv
module sim_irq_gather;

   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_i = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] exp_en = '0;

   always #5 clk = ~clk;

   irq_gather u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk);
      src_i = v;
      @(negedge clk);
   endtask

   task automatic check_state(input string req);
      logic [31:0] m, c, live;
      live = src_i & exp_en;
      chk({req, " irq"}, {31'd0, irq_out}, {31'd0, live != 0});
      rd(8'h04, m);
      chk({req, " mask"}, m, live);
      rd(8'h00, c);
      chk({req, " count"}, c, $countones(live));
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
      rd(8'h00, v); chk("R1 count after reset", v, 32'd0);
      rd(8'h04, v); chk("R1 mask after reset", v, 32'd0);
   endtask

   task automatic t_enable_set();
      set_src(32'h0000_00A5);
      check_state("R8 R9 no enables");
      wr(8'h10, 32'h0000_000F); exp_en = 32'h0000_000F;
      check_state("R3 R7 R8 low nibble");
      wr(8'h10, 32'h0000_00F0); exp_en = 32'h0000_00FF;
      check_state("R3 R7 second set keeps first");
      set_src(32'h0000_0000);
      check_state("R2 R9 lines low clear pending");
      set_src(32'h0000_0080);
      check_state("R2 R9 one line high");
   endtask

   task automatic t_disable();
      set_src(32'hFFFF_FFFF);
      wr(8'h0C, 32'h0000_000F); exp_en = 32'h0000_00F0;
      check_state("R4 clear low nibble");
      wr(8'h0C, 32'h0000_0000);
      check_state("R4 zero data no change");
   endtask

   task automatic t_full();
      wr(8'h10, 32'hFFFF_FFFF); exp_en = 32'hFFFF_FFFF;
      check_state("R7 all 32 live");
      set_src(32'h8000_0001);
      check_state("R7 edge bits only");
      set_src(32'hFFFF_FFFF);
   endtask

   task automatic t_kill();
      wr(8'h08, 32'h0000_0000); exp_en = '0;
      chk("R5 irq low after global clear", {31'd0, irq_out}, 32'd0);
      check_state("R5 enables gone");
      wr(8'h10, 32'h0000_0001); exp_en = 32'h0000_0001;
      chk("R6 held line pending again", {31'd0, irq_out}, 32'd1);
      check_state("R6 re-pended mask");
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h11, 32'hFFFF_FFFF);
      check_state("R10 ignored writes");
      rd(8'h14, v); chk("R10 unmapped read", v, 32'd0);
      rd(8'h10, v); chk("R10 write-only read", v, 32'd0);
      rd(8'h05, v); chk("R10 unaligned read", v, 32'd0);
   endtask

   task automatic t_latency();
      logic [31:0] v;
      rd(8'h04, v); chk("R11 read data next clock", v, 32'h0000_0001);
      @(negedge clk);
      chk("R11 idle rdata zero", bus_rdata, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_set();
      t_disable();
      t_full();
      t_kill();
      t_unmapped();
      t_latency();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule